// File: doc/BRIEF.md
# Multi-Pattern LED Bank Driver

This peripheral drives a bank of LEDs with one of three animated patterns: a binary count, a single lit bit that walks across the bank, and a strobe that flashes every LED on and off together. The pattern advances once per tick of an internal prescaler, so that the motion is slow enough to see. The pattern runs only while a chip-level enable input and a local enable bit are both set. A local pause bit freezes the pattern where it stands.

Software controls the block through a small register window on a simple generic bus. The bus carries address, write strobe, read strobe, write data, read data and an acknowledge. The window starts at a fixed base address. At the base address sits an 8-bit read/write control word, which holds the enable bit, the pause bit and a 3-bit pattern selector. The next address holds a read-only status word. It reports the selected pattern and whether the animation is running.

Top module: `led_pattern_ctrl`

## Requirements
- R1: After reset `led_o` is all zeros, `bus_ack_o` is low, `bus_rdata_o` is zero and the control word reads 0x01 (enabled, counting pattern, not paused).
- R2: Every cycle with `bus_wr_i` or `bus_rd_i` high is acknowledged by `bus_ack_o` high in the next cycle, and `bus_ack_o` is low otherwise. `bus_rdata_o` carries the read result in the acknowledge cycle of a read and is zero in every other cycle.
- R3: The control word at BASE_ADDR is 8 bits, read/write and fully stored. Bit 0 is the local enable, bit 1 is pause and bits 4:2 select the pattern.
- R4: The status word at BASE_ADDR+1 holds the pattern selector in bits 2:0 and a running flag in bit 7, with all other bits zero. The running flag is global enable AND local enable AND NOT pause. Writes to this address change nothing.
- R5: A read of any other address returns zero and is still acknowledged. A write to any other address changes nothing.
- R6: When `glbl_en_i` or the local enable bit is low, the pattern state and `led_o` hold their values.
- R7: While pause is set, the pattern state and `led_o` hold their values.
- R8: While the block is running, the pattern advances once every PRESCALE running cycles. The prescaler count holds while the block is not running.
- R9: Selector 0 (counting) shows a binary count on `led_o` that increases by one per advance and wraps.
- R10: Selector 1 (walking) shows exactly one lit LED. It moves one position toward the MSB per advance and wraps from the MSB back to bit 0.
- R11: Selector 2 (strobing) shows all LEDs on or all LEDs off, toggling per advance.
- R12: Selectors 3 to 7 are reserved and drive all LEDs off while the block is running.
- R13: `led_o` is registered. While running, it shows the selected pattern's current state one clock after each edge, so a new selector takes effect on the second edge after its write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| glbl_en_i | input | 1 | Chip-level enable |
| bus_addr_i | input | ADDR_W | Register address |
| bus_wr_i | input | 1 | Write strobe, one request per cycle |
| bus_rd_i | input | 1 | Read strobe, one request per cycle |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid with acknowledge |
| bus_ack_o | output | 1 | Acknowledge, one cycle after the request |
| led_o | output | NUM_LEDS | LED drive |

## Verification
The hardest case to reach is a pattern frozen in the middle of a prescaler period and then resumed. Resuming must continue from the same count phase, and the selector may have changed in between. The random stimulus therefore mixes control writes with random pause, enable and selector values, toggles of the global enable and idle gaps of random length. A cycle-accurate reference model in the bench checks the LED output every cycle. Directed sequences add the walking wrap across the MSB, exact advance counting over a window of full prescaler periods, and writes to the read-only and unmapped addresses.

// File: rtl/led_ctrl_pkg.sv
package led_ctrl_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned NUM_PAT = 3;

  localparam logic [2:0] SEL_COUNT  = 3'd0;
  localparam logic [2:0] SEL_WALK   = 3'd1;
  localparam logic [2:0] SEL_STROBE = 3'd2;

  typedef struct packed {
    logic [2:0] spare;
    logic [2:0] sel;
    logic       pause;
    logic       en;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{spare: 3'd0, sel: SEL_COUNT, pause: 1'b0, en: 1'b1};
endpackage

// File: rtl/led_regs.sv
module led_regs
  import led_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h8240
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              run_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              ack_o,
  output ctrl_t             ctrl_o
);
  localparam logic [ADDR_W-1:0] STAT_ADDR = BASE_ADDR + ADDR_W'(1);

  ctrl_t             ctrl_q;
  logic [REG_W-1:0]  rd_mux;

  always_comb begin
    rd_mux = '0;
    if (addr_i == BASE_ADDR)      rd_mux = ctrl_q;
    else if (addr_i == STAT_ADDR) rd_mux = {run_i, 4'b0000, ctrl_q.sel};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= CTRL_RST;
      rdata_o <= '0;
      ack_o   <= 1'b0;
    end else begin
      if (wr_i && addr_i == BASE_ADDR) ctrl_q <= ctrl_t'(wdata_i);
      ack_o   <= wr_i | rd_i;
      rdata_o <= rd_i ? rd_mux : '0;
    end
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/led_prescale.sv
module led_prescale #(
  parameter int unsigned DIV = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = active_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (tick_o)   cnt_q <= '0;
    else if (active_i) cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/led_patterns.sv
module led_patterns
  import led_ctrl_pkg::*;
#(
  parameter int unsigned NUM_LEDS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                active_i,
  input  logic                step_i,
  input  logic [2:0]          sel_i,
  output logic [NUM_LEDS-1:0] led_o
);
  logic [NUM_LEDS-1:0] pat [NUM_PAT];
  logic [NUM_LEDS-1:0] nxt;

  for (genvar g = 0; g < NUM_PAT; g++) begin : g_pat
    if (g == 0) begin : g_count
      logic [NUM_LEDS-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     cnt_q <= '0;
        else if (step_i) cnt_q <= cnt_q + NUM_LEDS'(1);
      end
      assign pat[g] = cnt_q;
    end else if (g == 1) begin : g_walk
      logic [NUM_LEDS-1:0] walk_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     walk_q <= NUM_LEDS'(1);
        else if (step_i) walk_q <= {walk_q[NUM_LEDS-2:0], walk_q[NUM_LEDS-1]};
      end
      assign pat[g] = walk_q;
    end else begin : g_strobe
      logic on_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     on_q <= 1'b0;
        else if (step_i) on_q <= ~on_q;
      end
      assign pat[g] = {NUM_LEDS{on_q}};
    end
  end

  // reserved selectors fall through to dark
  always_comb begin
    nxt = '0;
    for (int k = 0; k < NUM_PAT; k++)
      if (sel_i == 3'(k)) nxt = pat[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       led_o <= '0;
    else if (active_i) led_o <= nxt;
  end
endmodule

// File: rtl/led_pattern_ctrl.sv
module led_pattern_ctrl
  import led_ctrl_pkg::*;
#(
  parameter int unsigned NUM_LEDS = 8,
  parameter int unsigned ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h8240,
  parameter int unsigned PRESCALE = 1000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                glbl_en_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic                bus_wr_i,
  input  logic                bus_rd_i,
  input  logic [REG_W-1:0]    bus_wdata_i,
  output logic [REG_W-1:0]    bus_rdata_o,
  output logic                bus_ack_o,
  output logic [NUM_LEDS-1:0] led_o
);
  ctrl_t ctrl_q;
  logic  active;
  logic  tick;

  assign active = glbl_en_i & ctrl_q.en & ~ctrl_q.pause;

  led_regs #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (bus_addr_i),
    .wr_i    (bus_wr_i),
    .rd_i    (bus_rd_i),
    .wdata_i (bus_wdata_i),
    .run_i   (active),
    .rdata_o (bus_rdata_o),
    .ack_o   (bus_ack_o),
    .ctrl_o  (ctrl_q)
  );

  led_prescale #(.DIV(PRESCALE)) u_presc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .tick_o   (tick)
  );

  led_patterns #(.NUM_LEDS(NUM_LEDS)) u_pat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .step_i   (tick),
    .sel_i    (ctrl_q.sel),
    .led_o    (led_o)
  );
endmodule

// File: rtl/led_pattern_chk.sv
module led_pattern_chk #(
  parameter int unsigned NUM_LEDS = 8,
  parameter int unsigned ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h8240
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [ADDR_W-1:0]   bus_addr_i,
  input logic                bus_wr_i,
  input logic                bus_rd_i,
  input logic [7:0]          bus_rdata_o,
  input logic                bus_ack_o,
  input logic [NUM_LEDS-1:0] led_o,
  input logic [7:0]          ctrl_q,
  input logic                active
);
  localparam logic [ADDR_W-1:0] STAT_ADDR = BASE_ADDR + ADDR_W'(1);

  AST_ACK_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i || bus_rd_i) |=> bus_ack_o); // R2
  AST_NO_SPURIOUS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_wr_i || bus_rd_i) |=> !bus_ack_o); // R2
  AST_RDATA_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rd_i |=> bus_rdata_o == 8'h00); // R2
  AST_STATUS_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == STAT_ADDR) |=> $stable(ctrl_q)); // R4
  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |=> $stable(led_o)); // R6
  AST_WALK_ONE_LIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && ctrl_q[4:2] == 3'd1) |=> $countones(led_o) == 1); // R10
  AST_STROBE_UNIFORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && ctrl_q[4:2] == 3'd2) |=> (led_o == '0 || led_o == '1)); // R11
  AST_RESERVED_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && ctrl_q[4:2] > 3'd2) |=> led_o == '0); // R12
endmodule

bind led_pattern_ctrl led_pattern_chk #(
  .NUM_LEDS(NUM_LEDS), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_addr_i  (bus_addr_i),
  .bus_wr_i    (bus_wr_i),
  .bus_rd_i    (bus_rd_i),
  .bus_rdata_o (bus_rdata_o),
  .bus_ack_o   (bus_ack_o),
  .led_o       (led_o),
  .ctrl_q      (ctrl_q),
  .active      (active)
);

// File: tb/led_pattern_ctrl_test.sv
module led_pattern_ctrl_test;
  localparam int unsigned N = 8;
  localparam int unsigned AW = 16;
  localparam logic [AW-1:0] BASE = 16'h8240;
  localparam int unsigned P = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          glbl_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wr = 1'b0, rd = 1'b0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic          ack;
  logic [N-1:0]  led;

  int n_cmp = 0, n_bad = 0;
  bit live = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  led_pattern_ctrl #(.NUM_LEDS(N), .ADDR_W(AW), .BASE_ADDR(BASE), .PRESCALE(P)) uut (
    .clk_i(clk), .rst_ni(rst_n), .glbl_en_i(glbl_en), .bus_addr_i(addr),
    .bus_wr_i(wr), .bus_rd_i(rd), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .bus_ack_o(ack), .led_o(led)
  );

  // reference model built from the requirements
  logic [7:0]   m_ctrl;
  logic [7:0]   m_rdata;
  logic         m_ack;
  int unsigned  m_pc;
  logic [N-1:0] m_cnt, m_walk, m_led;
  logic         m_on;

  function automatic logic m_active();
    return glbl_en & m_ctrl[0] & ~m_ctrl[1];
  endfunction

  function automatic logic [7:0] m_read(logic [AW-1:0] a);
    if (a == BASE) return m_ctrl;
    if (a == BASE + 16'd1) return {m_active(), 4'b0000, m_ctrl[4:2]};
    return 8'h00; // R5
  endfunction

  function automatic logic [N-1:0] m_pattern();
    case (m_ctrl[4:2])
      3'd0: return m_cnt;          // R9
      3'd1: return m_walk;         // R10
      3'd2: return {N{m_on}};      // R11
      default: return '0;          // R12
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl <= 8'h01; m_rdata <= '0; m_ack <= 1'b0; m_pc <= 0;
      m_cnt <= '0; m_walk <= N'(1); m_on <= 1'b0; m_led <= '0;
    end else begin
      m_ack <= wr | rd;
      m_rdata <= rd ? m_read(addr) : 8'h00;
      if (wr && addr == BASE) m_ctrl <= wdata;
      if (m_active()) begin
        m_led <= m_pattern(); // R13
        if (m_pc == P - 1) begin // R8
          m_pc <= 0;
          m_cnt <= m_cnt + 1'b1;
          m_walk <= {m_walk[N-2:0], m_walk[N-1]};
          m_on <= ~m_on;
        end else m_pc <= m_pc + 1;
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string led_tag(logic [2:0] s);
    case (s)
      3'd0: return "R9";
      3'd1: return "R10";
      3'd2: return "R11";
      default: return "R12";
    endcase
  endfunction

  always @(negedge clk) begin
    if (live && rst_n && !done) begin
      check(led_tag(m_ctrl[4:2]), 32'(led), 32'(m_led));
      check("R2", 32'(ack), 32'(m_ack));
      check("R2", 32'(rdata), 32'(m_rdata));
    end
  end

  task automatic idle(int c);
    repeat (c) @(negedge clk);
  endtask

  task automatic bus_write(logic [AW-1:0] a, logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    check("R2", 32'(ack), 32'd1);
  endtask

  task automatic bus_read(string tag, logic [AW-1:0] a, logic [7:0] exp);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    check(tag, 32'(ack), 32'd1);
    check(tag, 32'(rdata), 32'(exp));
  endtask

  function automatic logic [7:0] cw(logic en, logic pause, logic [2:0] s);
    return {3'b000, s, pause, en};
  endfunction

  task automatic finish_run();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 150000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", wd);
      finish_run();
    end
  end

  initial begin
    logic [N-1:0] hold;
    int changes;
    void'($urandom(32'd20240611));
    idle(3);
    check("R1", 32'(led), 32'd0);
    check("R1", 32'(ack), 32'd0);
    check("R1", 32'(rdata), 32'd0);
    rst_n = 1'b1;
    live = 1'b1;
    idle(2);
    bus_read("R1", BASE, 8'h01);
    bus_read("R4", BASE + 16'd1, 8'h00);

    glbl_en = 1'b1;
    idle(6 * P);
    bus_read("R4", BASE + 16'd1, 8'h80);

    // R8: exactly one advance per P running cycles
    changes = 0;
    for (int i = 0; i < 8 * P; i++) begin
      hold = led;
      @(negedge clk);
      if (led !== hold) changes++;
    end
    check("R8", 32'(changes), 32'd8);

    // R3: full readback of control
    bus_write(BASE, 8'hE3 ^ 8'h02);
    bus_read("R3", BASE, 8'hE1);
    bus_write(BASE, cw(1, 0, 3'd0));

    // R7: pause freezes
    bus_write(BASE, cw(1, 1, 3'd0));
    idle(2);
    hold = led;
    idle(5 * P + 3);
    check("R7", 32'(led), 32'(hold));
    bus_read("R4", BASE + 16'd1, 8'h00);
    bus_write(BASE, cw(1, 0, 3'd0));
    idle(3 * P);

    // R6: global enable low freezes
    glbl_en = 1'b0;
    idle(2);
    hold = led;
    idle(5 * P);
    check("R6", 32'(led), 32'(hold));
    glbl_en = 1'b1;
    // R6: local enable low freezes
    bus_write(BASE, cw(0, 0, 3'd1));
    idle(2);
    hold = led;
    idle(4 * P);
    check("R6", 32'(led), 32'(hold));

    // R10: walking over more than one lap
    bus_write(BASE, cw(1, 0, 3'd1));
    for (int i = 0; i < 3 * N; i++) begin
      idle(P);
      check("R10", 32'($countones(led)), 32'd1);
    end

    // R11: strobe
    bus_write(BASE, cw(1, 0, 3'd2));
    idle(2);
    for (int i = 0; i < 6; i++) begin
      idle(P);
      check("R11", 32'((led == '0) || (led == '1)), 32'd1);
    end

    // R12: reserved selectors dark
    for (int s = 3; s < 8; s++) begin
      bus_write(BASE, cw(1, 0, 3'(s)));
      idle(2);
      check("R12", 32'(led), 32'd0);
      bus_read("R4", BASE + 16'd1, {1'b1, 4'b0000, 3'(s)});
    end

    // R4: status not writable; R5: unmapped
    bus_write(BASE, cw(1, 0, 3'd0));
    bus_write(BASE + 16'd1, 8'hFF);
    bus_read("R4", BASE, 8'h01);
    bus_write(BASE + 16'd2, 8'h5A);
    bus_write(BASE - 16'd1, 8'h5A);
    bus_read("R5", BASE, 8'h01);
    bus_read("R5", BASE + 16'd2, 8'h00);
    bus_read("R5", BASE - 16'd1, 8'h00);
    bus_read("R5", 16'h0000, 8'h00);

    // random mix, checked by the model every cycle (R13)
    for (int it = 0; it < 400; it++) begin
      int op;
      op = int'($urandom_range(0, 5));
      case (op)
        0, 1: bus_write(BASE, cw(1'($urandom_range(0, 4) != 0), 1'($urandom_range(0, 3) == 0),
                                 3'($urandom_range(0, 7))));
        2: glbl_en = 1'($urandom_range(0, 4) != 0);
        3: begin
          logic [AW-1:0] a;
          a = BASE + AW'($urandom_range(0, 3)) - AW'(1);
          bus_read("R13", a, m_read(a));
        end
        4: bus_write(BASE + AW'($urandom_range(1, 5)), 8'($urandom));
        default: ;
      endcase
      idle(int'($urandom_range(0, 3 * P)));
    end
    glbl_en = 1'b1;
    idle(4);
    finish_run();
  end
endmodule